// File: doc/BRIEF.md
# Alternating I/Q Word Serializer

This block sits on the read side of a standard FIFO that holds fixed-width words. When it has no work, it looks at the FIFO's empty flag. If a word is waiting, it issues a one-cycle read request and captures the word on the next cycle. It then sends the word out one bit per clock on a serial pin, starting with the least significant bit.

Words take turns on two pins. The first word after reset goes to the I pin, the next to the Q pin, and the pattern repeats. Once a word has been loaded it is always sent to the end, whatever the FIFO does. The block looks at the FIFO again only after the last bit of the current word has been sent.

The FIFO is assumed to present its read data one cycle after the read request, not ahead of it. A `busy` output tells the surrounding logic when a transfer is in flight.

Top module: `iq_serializer`

## Requirements
- R1: Each loaded word is sent over exactly WORD_W consecutive clock cycles, one bit per cycle, with no gap inside the word.
- R2: Bit 0 of the word is sent first and bit WORD_W-1 last.
- R3: The first word after reset is sent on `pin_i`. Each later word goes to the other pin from the one before it (I, Q, I, Q, ...).
- R4: Once a word has been loaded, sending continues to its last bit even if the FIFO is empty. After that the block goes idle and stays idle while the FIFO stays empty.
- R5: `fifo_rd_en` is high only when `fifo_empty` is low and no word is being fetched or sent. It is high for one cycle per word.
- R6: `fifo_rd_data` is captured on the clock edge that follows the `fifo_rd_en` cycle. Bit 0 appears on the selected pin in the cycle after that capture edge.
- R7: The pin that is not carrying the current word is held at 0. When no word is being sent, both pins are 0.
- R8: `busy` is high from the cycle in which `fifo_rd_en` is asserted through the cycle that carries the last bit. It is low otherwise.
- R9: A synchronous active-high `rst` takes both pins and `busy` low on the next edge and abandons any word in progress. The next word after reset goes to `pin_i`.
- R10: `fifo_rd_data` is ignored in every cycle except the one that follows `fifo_rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_rd_data | input | WORD_W | FIFO read data, valid the cycle after a read |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_rd_en | output | 1 | One-cycle read request to the FIFO |
| pin_i | output | 1 | Serial output for words 0, 2, 4, ... |
| pin_q | output | 1 | Serial output for words 1, 3, 5, ... |
| busy | output | 1 | A word is being fetched or sent |

## Verification
The assertions assume that the FIFO never lowers `fifo_empty` without a word behind it. They also assume that read data is valid exactly one cycle after a read request. The bench FIFO model meets both assumptions: it updates its empty flag only on clock edges, from its own queue, and it loads the output register only when a read request pops that queue. In every other cycle the model drives random values on `fifo_rd_data`, so any use of stale data shows up on the pins. Pushes arrive in bursts, one at a time, and while a word is still being sent, including an empty FIFO in the middle of a word.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } iqs_state_e;

   typedef enum logic {
      LANE_I = 1'b0,
      LANE_Q = 1'b1
   } iqs_lane_e;

   localparam int IQS_LANES = 2;

endpackage

// File: rtl/iqs_fetch_ctrl.sv
module iqs_fetch_ctrl
   import iqs_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int CNT_W = $clog2(WORD_W) + 1
) (
   input  logic clk,
   input  logic rst,
   input  logic fifo_empty,
   output logic rd_en,
   output logic load_en,
   output logic shift_en,
   output logic word_done,
   output logic busy
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   iqs_state_e       state_q, state_d;
   logic [CNT_W-1:0] bit_cnt_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (!fifo_empty) state_d = ST_WAIT;
         ST_WAIT:  state_d = ST_SHIFT;
         ST_SHIFT: if (bit_cnt_q == LAST_IDX) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
      end else begin
         state_q <= state_d;
         if (load_en || word_done)
            bit_cnt_q <= '0;
         else if (shift_en)
            bit_cnt_q <= bit_cnt_q + 1'b1;
      end
   end

   assign rd_en     = !rst && (state_q == ST_IDLE) && !fifo_empty;
   assign load_en   = (state_q == ST_WAIT);
   assign shift_en  = (state_q == ST_SHIFT);
   assign word_done = shift_en && (bit_cnt_q == LAST_IDX);
   assign busy      = (state_q != ST_IDLE) || rd_en;

endmodule

// File: rtl/iqs_shift_reg.sv
module iqs_shift_reg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] load_data,
   output logic              ser_bit
);

   logic [WORD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (load_en)
         hold_q <= load_data;
      else if (shift_en)
         hold_q <= {1'b0, hold_q[WORD_W-1:1]};
   end

   assign ser_bit = hold_q[0];

endmodule

// File: rtl/iqs_lane_steer.sv
module iqs_lane_steer
   import iqs_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic word_done,
   input  logic shifting,
   input  logic ser_bit,
   output logic pin_i,
   output logic pin_q
);

   iqs_lane_e              lane_q;
   logic [IQS_LANES-1:0]   lane_out;

   always_ff @(posedge clk) begin
      if (rst)
         lane_q <= LANE_I;
      else if (word_done)
         lane_q <= (lane_q == LANE_I) ? LANE_Q : LANE_I;
   end

   for (genvar l = 0; l < IQS_LANES; l++) begin : g_lane
      assign lane_out[l] = shifting && (int'(lane_q) == l) && ser_bit;
   end

   assign pin_i = lane_out[int'(LANE_I)];
   assign pin_q = lane_out[int'(LANE_Q)];

endmodule

// File: rtl/iq_serializer.sv
module iq_serializer #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] fifo_rd_data,
   input  logic              fifo_empty,
   output logic              fifo_rd_en,
   output logic              pin_i,
   output logic              pin_q,
   output logic              busy
);

   if (WORD_W < 2) begin : g_bad_width
      $error("iq_serializer: WORD_W must be at least 2");
   end

   logic load_en;
   logic shift_en;
   logic word_done;
   logic ser_bit;

   iqs_fetch_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .fifo_empty(fifo_empty),
      .rd_en     (fifo_rd_en),
      .load_en   (load_en),
      .shift_en  (shift_en),
      .word_done (word_done),
      .busy      (busy)
   );

   iqs_shift_reg #(.WORD_W(WORD_W)) u_shreg (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .shift_en (shift_en),
      .load_data(fifo_rd_data),
      .ser_bit  (ser_bit)
   );

   iqs_lane_steer u_steer (
      .clk      (clk),
      .rst      (rst),
      .word_done(word_done),
      .shifting (shift_en),
      .ser_bit  (ser_bit),
      .pin_i    (pin_i),
      .pin_q    (pin_q)
   );

endmodule

// File: rtl/iq_serializer_chk.sv
module iq_serializer_chk #(
   parameter int WORD_W = 32
) (
   input logic clk,
   input logic rst,
   input logic fifo_empty,
   input logic fifo_rd_en,
   input logic pin_i,
   input logic pin_q,
   input logic busy
);

   // Cycles elapsed since the last read request; 0 = no word in flight.
   int since_rd;

   always_ff @(posedge clk) begin
      if (rst)
         since_rd <= 0;
      else if (fifo_rd_en)
         since_rd <= 1;
      else if (since_rd != 0 && since_rd < WORD_W + 1)
         since_rd <= since_rd + 1;
      else
         since_rd <= 0;
   end

   // R5
   rd_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_rd_en |-> !fifo_empty);

   // R5
   rd_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_rd_en |-> since_rd == 0);

   // R8
   busy_in_word_chk: assert property (@(posedge clk) disable iff (rst)
      since_rd != 0 |-> busy);

   // R8
   busy_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rd == 0 && !fifo_rd_en) |-> !busy);

   // R7
   one_pin_chk: assert property (@(posedge clk) disable iff (rst)
      !(pin_i && pin_q));

   // R7
   quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!pin_i && !pin_q));

   // R6
   no_early_bit_chk: assert property (@(posedge clk) disable iff (rst)
      since_rd < 2 |-> (!pin_i && !pin_q));

endmodule

bind iq_serializer iq_serializer_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .fifo_empty(fifo_empty),
   .fifo_rd_en(fifo_rd_en),
   .pin_i     (pin_i),
   .pin_q     (pin_q),
   .busy      (busy)
);

// File: tb/iq_serializer_bench.sv
module iq_serializer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 32;
   localparam int WATCHDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [WORD_W-1:0] fifo_dout = '0;
   logic              fifo_empty = 1'b1;
   logic              fifo_rd_en, pin_i, pin_q, busy;

   logic [WORD_W-1:0] fifo_q[$];
   int n_checks = 0;
   int n_errors = 0;

   // reference model: 0 idle, 1 waiting for data, 2 sending
   int                m_phase = 0;
   int                m_cnt   = 0;
   int                m_lane  = 0;
   logic [WORD_W-1:0] m_word  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iq_serializer #(.WORD_W(WORD_W)) u_iq_serializer (
      .clk         (clk),
      .rst         (rst),
      .fifo_rd_data(fifo_dout),
      .fifo_empty  (fifo_empty),
      .fifo_rd_en  (fifo_rd_en),
      .pin_i       (pin_i),
      .pin_q       (pin_q),
      .busy        (busy)
   );

   task automatic check_bit(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic exp_rd();
      return !rst && m_phase == 0 && !fifo_empty;
   endfunction

   function automatic logic exp_pin(int lane);
      return m_phase == 2 && m_lane == lane && m_word[m_cnt];
   endfunction

   // reference model and behavioural FIFO
   always @(posedge clk) begin : ref_model
      logic take;
      take = exp_rd();
      if (rst) begin
         m_phase = 0; m_cnt = 0; m_lane = 0;
      end else begin
         case (m_phase)
            0: if (take) begin m_word = fifo_q[0]; m_phase = 1; end
            1: begin m_phase = 2; m_cnt = 0; end
            default: if (m_cnt == WORD_W - 1) begin
                        m_phase = 0; m_lane = 1 - m_lane;
                     end else m_cnt++;
         endcase
      end
      // R10: outside a read response the data bus carries junk
      if (fifo_rd_en && fifo_q.size() != 0) fifo_dout <= fifo_q.pop_front();
      else                                  fifo_dout <= $urandom;
      fifo_empty <= (fifo_q.size() == 0);
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      check_bit("R5", "fifo_rd_en", fifo_rd_en, exp_rd());
      check_bit("R8", "busy", busy, (m_phase != 0) || exp_rd());
      check_bit("R1 R2 R3 R4 R6 R7 R10", "pin_i", pin_i, exp_pin(0));
      check_bit("R1 R2 R3 R4 R6 R7 R10", "pin_q", pin_q, exp_pin(1));
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      rst = 1'b1;
      step(3);
      @(negedge clk);
      // R9 reset state
      check_bit("R9", "busy after reset", busy, 1'b0);
      check_bit("R9", "pins after reset", pin_i | pin_q, 1'b0);
      step(1);
      rst = 1'b0;
      step(2);

      // single word to pin I, FIFO then empty (R3, R4)
      fifo_q.push_back(32'h0000_0001);
      step(45);
      @(negedge clk);
      check_bit("R4", "idle after lone word", busy, 1'b0);
      step(1);

      // burst of words back to back
      fifo_q.push_back(32'hFFFF_FFFF);
      fifo_q.push_back(32'hA5A5_3C3C);
      fifo_q.push_back(32'h8000_0000);
      fifo_q.push_back(32'h0000_0000);
      step(160);

      // word pushed while another is in flight
      fifo_q.push_back(32'h1234_5678);
      step(10);
      fifo_q.push_back(32'h0F0F_F0F0);
      step(90);

      // R9 reset in the middle of a word
      fifo_q.push_back(32'hDEAD_BEEF);
      fifo_q.push_back(32'hCAFE_F00D);
      step(20);
      rst = 1'b1;
      step(2);
      @(negedge clk);
      check_bit("R9", "busy in reset", busy, 1'b0);
      check_bit("R9", "pins in reset", pin_i | pin_q, 1'b0);
      step(1);
      rst = 1'b0;
      step(80);

      // random words with random gaps
      for (int k = 0; k < 8; k++) begin
         fifo_q.push_back($urandom);
         step($urandom_range(0, 50));
      end
      step(300);
      @(negedge clk);
      check_bit("R4", "drained and idle", busy | pin_i | pin_q, 1'b0);

      report();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
   end

endmodule